// File: doc/BRIEF.md
# Read Port Undefined-Value Injector

This block sits on the read side of a synchronous 32-bit memory. It replaces every read result that the memory does not define with a pseudo-random word. It watches the read request (enable and address), the write request (enable and address) and the data the memory returns. A read counts as undefined in three cases: the read is not enabled; the address is at or beyond the configured depth; or, with one cycle of read latency and undefined read-during-write behaviour, the read hits the address being written in the same cycle.

The undefined decision is taken in the request cycle. With read latency 1 it is delayed by one register so that it lines up with the data the memory returns. The random word comes from a 32-bit Galois LFSR. The LFSR steps only after a cycle in which the output carried a random word, so a formal tool or a simulation sees a fresh value for each undefined read. When the depth fills the whole address space, the bound comparison is not built. An optional checker raises an error flag for writes aimed past the depth. The RAM itself is outside the block.

Top module: `rd_undef_guard`

## Requirements
- R1: With read latency 1, an enabled read with address below DEPTH that does not collide with a write drives rd_data_o equal to mem_rdata_i in the following cycle. That cycle is when the memory presents the stored word.
- R2: A read with rd_en_i low makes rd_data_o carry the random word in the cycle where its data would appear.
- R3: An enabled read with rd_addr_i >= DEPTH (DEPTH = 30 by default) makes rd_data_o carry the random word.
- R4: With read latency 1 and read-during-write undefined, a read is randomized when rd_en_i and wr_en_i are both high and rd_addr_i equals wr_addr_i. If the addresses differ, the read returns memory data.
- R5: The random word is a 32-bit Galois LFSR with seed 32'h0000_0001. Each step shifts right by one and, when the bit shifted out is 1, XORs the result with 32'h8020_0003. The LFSR steps on a clock edge only when the output during the preceding cycle was the random word. Consecutive randomized reads therefore see consecutive LFSR states.
- R6: The decision flag is delayed by the read latency and cleared by reset. While rst_ni is low, rd_data_o equals mem_rdata_i.
- R7: With the write check enabled, wr_oob_err_o is high for exactly the cycle after a clock edge at which wr_en_i was high and wr_addr_i >= DEPTH. Otherwise it is low, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the memory ports |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read enable of the guarded port |
| rd_addr_i | input | AW | Read address |
| mem_rdata_i | input | 32 | Data returned by the memory |
| wr_en_i | input | 1 | Write enable of the memory's write port |
| wr_addr_i | input | AW | Write address |
| rd_data_o | output | 32 | Read data after undefined-value substitution |
| wr_oob_err_o | output | 1 | Registered flag for an out-of-range write |

## Verification
The assertions assume two things. First, mem_rdata_i behaves like a synchronous memory whose latency matches READ_LAT. Second, the request inputs change only between clock edges. The bench meets both: it models the RAM with a registered read of its own array, and it drives every input at the falling edge. Addresses sweep the whole 5-bit space. The sweeps cover writes and reads past depth 30, same-address and neighbouring-address read/write pairs, and runs of disabled reads, so the LFSR is exercised both across consecutive randomized cycles and across gaps between them.

// File: rtl/rdinj_pkg.sv
package rdinj_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] LFSR_POLY = 32'h8020_0003;

  function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] s);
    lfsr_step = s[0] ? ((s >> 1) ^ LFSR_POLY) : (s >> 1);
  endfunction
endpackage

// File: rtl/rdinj_bound.sv
module rdinj_bound #(
  parameter int unsigned AW    = 5,
  parameter int unsigned DEPTH = 30
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          oob_o
);
  localparam bit          FULL    = (DEPTH == (1 << AW));
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  generate
    if (FULL) begin : g_full
      assign oob_o = 1'b0;
    end else begin : g_part
      assign oob_o = en_i & ({1'b0, addr_i} >= DEPTH_W);
    end
  endgenerate
endmodule

// File: rtl/rdinj_lfsr.sv
module rdinj_lfsr
  import rdinj_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 32'h0000_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] state_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
      seen_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (adv_i) state_q <= lfsr_step(state_q);
    end
  end

  assign word_o = state_q;

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) state_q != '0);
  // R5
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(adv_i)) |-> $stable(state_q));
  // R5
  lfsr_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(adv_i)) |-> (state_q != $past(state_q)));
endmodule

// File: rtl/rdinj_align.sv
module rdinj_align #(
  parameter int unsigned LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic sel_o
);
  generate
    if (LAT == 0) begin : g_comb
      assign sel_o = flag_i;
    end else begin : g_reg
      logic flag_q;
      logic seen_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= 1'b0;
          seen_q <= 1'b0;
        end else begin
          flag_q <= flag_i;
          seen_q <= 1'b1;
        end
      end
      assign sel_o = flag_q;

      // R6
      sel_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> (sel_o == $past(flag_i)));
    end
  endgenerate
endmodule

// File: rtl/rdinj_wr_check.sv
module rdinj_wr_check #(
  parameter int unsigned AW     = 5,
  parameter int unsigned DEPTH  = 30,
  parameter bit          ENABLE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          err_o
);
  generate
    if (ENABLE) begin : g_on
      logic hit;
      logic err_q;
      logic seen_q;
      rdinj_bound #(.AW(AW), .DEPTH(DEPTH)) u_bound (
        .en_i  (wr_en_i),
        .addr_i(wr_addr_i),
        .oob_o (hit)
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          err_q  <= 1'b0;
          seen_q <= 1'b0;
        end else begin
          err_q  <= hit;
          seen_q <= 1'b1;
        end
      end
      assign err_o = err_q;

      // R7
      wr_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> (err_o == $past(wr_en_i && ({1'b0, wr_addr_i} >= (AW+1)'(DEPTH)))));
    end else begin : g_off
      assign err_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rd_undef_guard.sv
module rd_undef_guard
  import rdinj_pkg::*;
#(
  parameter int unsigned     AW        = 5,
  parameter int unsigned     DEPTH     = 30,
  parameter int unsigned     READ_LAT  = 1,
  parameter bit              RUW_UNDEF = 1'b1,
  parameter bit              WR_CHECK  = 1'b1,
  parameter logic [DW-1:0]   SEED      = 32'h0000_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_oob_err_o
);
  localparam bit USE_RWC = (READ_LAT == 1) && RUW_UNDEF;

  logic          rd_off, rd_oob, rd_rwc, do_rand, sel;
  logic [DW-1:0] rnd;

  assign rd_off = ~rd_en_i;

  rdinj_bound #(.AW(AW), .DEPTH(DEPTH)) u_rd_bound (
    .en_i  (rd_en_i),
    .addr_i(rd_addr_i),
    .oob_o (rd_oob)
  );

  generate
    if (USE_RWC) begin : g_rwc
      assign rd_rwc = rd_en_i & wr_en_i & (rd_addr_i == wr_addr_i);
    end else begin : g_no_rwc
      assign rd_rwc = 1'b0;
    end
  endgenerate

  assign do_rand = rd_off | rd_oob | rd_rwc;

  rdinj_align #(.LAT(READ_LAT)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(do_rand),
    .sel_o (sel)
  );

  rdinj_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (sel),
    .word_o(rnd)
  );

  assign rd_data_o = sel ? rnd : mem_rdata_i;

  rdinj_wr_check #(.AW(AW), .DEPTH(DEPTH), .ENABLE(WR_CHECK)) u_wr_check (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .err_o    (wr_oob_err_o)
  );

  generate
    if (READ_LAT == 1) begin : g_chk1
      logic seen_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
      end
      // R1
      pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(rd_en_i && ({1'b0, rd_addr_i} < (AW+1)'(DEPTH))
                         && !(USE_RWC && wr_en_i && rd_addr_i == wr_addr_i)))
        |-> (rd_data_o == mem_rdata_i));
      // R2
      off_rand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(!rd_en_i)) |-> (rd_data_o == rnd));
    end
  endgenerate
endmodule

// File: tb/rd_undef_guard_tb_top.sv
module rd_undef_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0]  rd_addr = '0, wr_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] ram [32];
  logic [31:0] ram_q = '0;
  logic [31:0] rd_data;
  logic        wr_err;

  logic [31:0] exp_mem [32];
  logic [31:0] model_lfsr = 32'h0000_0001;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    ram_q <= ram[rd_addr];
    if (wr_en) ram[wr_addr] <= wdata;
  end

  rd_undef_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .mem_rdata_i(ram_q), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .rd_data_o(rd_data), .wr_oob_err_o(wr_err)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    step = s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic ren, input logic [4:0] ra,
                       input logic wen, input logic [4:0] wa, input logic [31:0] wd);
    logic        f_off, f_oob, f_rwc, flag, exp_err;
    logic [31:0] exp_d;
    string       tag;
    @(negedge clk);
    rd_en = ren; rd_addr = ra; wr_en = wen; wr_addr = wa; wdata = wd;
    f_off = !ren;
    f_oob = ren && (ra >= 5'd30);
    f_rwc = ren && wen && (ra == wa);
    flag  = f_off | f_oob | f_rwc;
    exp_d = flag ? model_lfsr : exp_mem[ra];
    exp_err = wen && (wa >= 5'd30);
    if (f_off) tag = "R2";
    else if (f_oob) tag = "R3";
    else if (f_rwc) tag = "R4";
    else if (wen) tag = "R4";
    else tag = "R1";
    @(posedge clk);
    if (wen) exp_mem[wa] = wd;
    #2;
    check(flag ? {tag, "/R5"} : tag, rd_data, exp_d);
    check("R7", {31'b0, wr_err}, {31'b0, exp_err});
    if (flag) model_lfsr = step(model_lfsr);
  endtask

  initial begin
    #2;
    // R6: reset state
    check("R6", rd_data, 32'h0);
    check("R7", {31'b0, wr_err}, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // fill every address, reads disabled; writes at 30/31 raise the error
    for (int a = 0; a < 32; a++) cycle(1'b0, 5'(a), 1'b1, 5'(a), a * 32'h9E37_79B9 + 32'h11);
    // read sweep, including out-of-range
    for (int a = 0; a < 32; a++) cycle(1'b1, 5'(a), 1'b0, 5'd0, 32'h0);
    // same-address collisions and neighbour writes
    for (int a = 0; a < 30; a++) begin
      cycle(1'b1, 5'(a), 1'b1, 5'(a), 32'hC0DE_0000 + 32'(a));
      cycle(1'b1, 5'(a), 1'b1, 5'((a + 1) % 30), 32'hBEEF_0000 + 32'(a));
    end
    // run of disabled reads: successive LFSR states
    for (int k = 0; k < 8; k++) cycle(1'b0, 5'(k * 3), 1'b0, 5'd0, 32'h0);
    // interleaved defined / undefined reads
    for (int a = 0; a < 32; a++) begin
      cycle(1'b1, 5'(a), 1'b0, 5'd0, 32'h0);
      cycle(1'b0, 5'(a), 1'b0, 5'd0, 32'h0);
    end
    // R6: reset again clears decision flag and error
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; wr_addr = 5'd31;
    rst_n = 1'b0;
    #1;
    check("R6", rd_data, ram_q);
    check("R7", {31'b0, wr_err}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule